// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry

This block is the control-state machine of a small processor. It walks the processor through every phase of one instruction: next-address calculation, fetch, decode, read-side operand address calculation, operand fetch, data operation, write-side operand address calculation and operand store. An interrupt check closes the cycle. For each state it raises the strobes that the datapath and the memory/IO port act on. The datapath, the ALU and memory contents lie outside the block. The block only sequences them.

The decoder supplies four instruction class flags while the sequencer sits in its decode state. The flags say whether the instruction reads a memory operand, writes a result to memory, is a control transfer (jump), or returns from an interrupt handler. The sequencer latches them in that state. An instruction without a read operand goes from decode straight to the data operation. An instruction without a store goes from the data operation straight to the interrupt check. Memory-facing states hold their request until the ready input is high. Internal states last one clock. When the interrupt line is high at the check, the block spends one clock saving context and one clock loading the PC with the handler address, and then starts a new cycle.

Top module: `icy_sequencer`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) puts the block in the address-calculation state with every strobe low. A reset taken in the middle of an instruction also returns it there.
- R2: The state vector is one-hot with these bit positions: 0 address calc, 1 fetch, 2 decode, 3 read-operand address, 4 operand fetch, 5 data operation, 6 write-operand address, 7 operand store, 8 interrupt check, 9 context save, 10 vector load. Address calc lasts one clock and is followed by fetch. Fetch raises `mem_rd_o` and stays put while `mem_rdy_i` is low.
- R3: `pc_inc_o` is high only in the fetch cycle in which `mem_rdy_i` is high. Decode always follows that cycle.
- R4: From decode, the block goes to read-operand address when `cls_rd_i` is high, and otherwise goes directly to data operation.
- R5: Read-operand address lasts one clock and leads to operand fetch. Operand fetch raises `mem_rd_o`, holds until `mem_rdy_i` is high, then goes to data operation.
- R6: Data operation lasts one clock. It leads to write-operand address and then operand store when the latched write flag is set, and otherwise to the interrupt check. Operand store raises `mem_wr_o`, holds until ready, then goes to the interrupt check.
- R7: At the interrupt check, a low `irq_i` leads back to address calc. A high `irq_i` leads to context save (`ctx_save_o` for one clock), then vector load (`pc_vec_o` for one clock), then address calc.
- R8: `pc_jump_o` is high during data operation exactly when the latched jump flag is set, and never in any other state.
- R9: `ctx_restore_o` is high during data operation exactly when the latched return-from-interrupt flag is set, and never in any other state.
- R10: Exactly one state bit is high in every cycle.
- R11: The class flags are sampled only in decode. Their values in any other state have no effect on the path or the strobes.
- R12: `irq_i` is sampled only at the interrupt check. `mem_rdy_i` has no effect in internal states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cls_rd_i | input | 1 | Instruction reads a memory operand (valid in decode) |
| cls_wr_i | input | 1 | Instruction stores a result (valid in decode) |
| cls_jmp_i | input | 1 | Instruction is a control transfer (valid in decode) |
| cls_rti_i | input | 1 | Instruction returns from an interrupt (valid in decode) |
| mem_rdy_i | input | 1 | Memory/IO ready for the current access |
| irq_i | input | 1 | Interrupt pending |
| state_oh_o | output | 11 | One-hot state indicators |
| mem_rd_o | output | 1 | Memory read request (fetch, operand fetch) |
| mem_wr_o | output | 1 | Memory write request (operand store) |
| pc_inc_o | output | 1 | Advance PC by the fixed step |
| pc_jump_o | output | 1 | Load PC from the jump target |
| pc_vec_o | output | 1 | Load PC with the handler start address |
| ctx_save_o | output | 1 | Save processor context |
| ctx_restore_o | output | 1 | Restore context and saved PC |

## Verification
Each instruction is driven as a class combination (read, write, both, neither, with or without jump or return), random wait lengths on each memory access, and a random interrupt at the check. The bench tracks the expected state cycle by cycle, so a wrong skip, a missing hold or a wrongly placed strobe is caught in the cycle where it happens. The class flags, `irq_i` and ready are given random values outside the states that may sample them, which separates a design that samples only in the right state from one that samples all the time. Directed cases cover long waits, back-to-back interrupts and a reset taken during an operand fetch.

// File: rtl/icy_pkg.sv
// Shared types for the instruction cycle sequencer.
// Assumes: the state encoding below is also the bit order of the one-hot output.
package icy_pkg;
    typedef enum logic [3:0] {
        ST_IAC  = 4'd0,
        ST_IF   = 4'd1,
        ST_IOD  = 4'd2,
        ST_OACR = 4'd3,
        ST_OF   = 4'd4,
        ST_DO   = 4'd5,
        ST_OACW = 4'd6,
        ST_OS   = 4'd7,
        ST_ICHK = 4'd8,
        ST_ISAV = 4'd9,
        ST_IVEC = 4'd10
    } icy_state_e;

    localparam int unsigned ICY_NUM_ST = 11;

    typedef struct packed {
        logic rd;
        logic wr;
        logic jmp;
        logic rti;
    } icy_class_t;
endpackage

// File: rtl/icy_next_state.sv
// Next-state logic of the instruction cycle.
// Assumes: live_cls is valid only in decode; lat_cls holds the flags latched there.
module icy_next_state
    import icy_pkg::*;
(
    input  icy_state_e cur_i,
    input  icy_class_t live_cls_i,
    input  icy_class_t lat_cls_i,
    input  logic       rdy_i,
    input  logic       irq_i,
    output icy_state_e nxt_o
);
    // Pick the successor state from the current state and the sampled inputs.
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            ST_IAC:  nxt_o = ST_IF;
            ST_IF:   nxt_o = rdy_i ? ST_IOD : ST_IF;
            ST_IOD:  nxt_o = live_cls_i.rd ? ST_OACR : ST_DO;
            ST_OACR: nxt_o = ST_OF;
            ST_OF:   nxt_o = rdy_i ? ST_DO : ST_OF;
            ST_DO:   nxt_o = lat_cls_i.wr ? ST_OACW : ST_ICHK;
            ST_OACW: nxt_o = ST_OS;
            ST_OS:   nxt_o = rdy_i ? ST_ICHK : ST_OS;
            ST_ICHK: nxt_o = irq_i ? ST_ISAV : ST_IAC;
            ST_ISAV: nxt_o = ST_IVEC;
            ST_IVEC: nxt_o = ST_IAC;
            default: nxt_o = ST_IAC;
        endcase
    end
endmodule

// File: rtl/icy_strobe_dec.sv
// Decodes the current state into one-hot indicators and datapath strobes.
// Assumes: lat_cls is stable from decode to the end of the instruction.
module icy_strobe_dec
    import icy_pkg::*;
#(
    parameter int unsigned NUM_ST = ICY_NUM_ST
) (
    input  icy_state_e        cur_i,
    input  icy_class_t        lat_cls_i,
    input  logic              rdy_i,
    output logic [NUM_ST-1:0] state_oh_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              pc_inc_o,
    output logic              pc_jump_o,
    output logic              pc_vec_o,
    output logic              ctx_save_o,
    output logic              ctx_restore_o
);
    // One indicator bit per state, in encoding order.
    for (genvar g = 0; g < NUM_ST; g++) begin : g_oh
        assign state_oh_o[g] = (32'(cur_i) == g);
    end

    // Strobes that follow directly from the state and the memory handshake.
    always_comb begin
        mem_rd_o      = (cur_i == ST_IF) || (cur_i == ST_OF);
        mem_wr_o      = (cur_i == ST_OS);
        pc_inc_o      = (cur_i == ST_IF) && rdy_i;
        pc_jump_o     = (cur_i == ST_DO) && lat_cls_i.jmp;
        ctx_restore_o = (cur_i == ST_DO) && lat_cls_i.rti;
        ctx_save_o    = (cur_i == ST_ISAV);
        pc_vec_o      = (cur_i == ST_IVEC);
    end
endmodule

// File: rtl/icy_sequencer.sv
// Instruction cycle sequencer: state register, class latch, and the
// next-state and strobe decoders.
// Assumes: rst_n is synchronous and active low; class flags are valid in decode.
module icy_sequencer
    import icy_pkg::*;
#(
    parameter int unsigned NUM_ST = ICY_NUM_ST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cls_rd_i,
    input  logic              cls_wr_i,
    input  logic              cls_jmp_i,
    input  logic              cls_rti_i,
    input  logic              mem_rdy_i,
    input  logic              irq_i,
    output logic [NUM_ST-1:0] state_oh_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              pc_inc_o,
    output logic              pc_jump_o,
    output logic              pc_vec_o,
    output logic              ctx_save_o,
    output logic              ctx_restore_o
);
    icy_state_e cur_q, nxt;
    icy_class_t live_cls, lat_q;

    assign live_cls = '{rd: cls_rd_i, wr: cls_wr_i, jmp: cls_jmp_i, rti: cls_rti_i};

    // State register with synchronous reset to address calculation.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_IAC;
        else        cur_q <= nxt;
    end

    // Capture the instruction class once, in decode.
    always_ff @(posedge clk) begin
        if (!rst_n)              lat_q <= '0;
        else if (cur_q == ST_IOD) lat_q <= live_cls;
    end

    icy_next_state u_next (
        .cur_i      (cur_q),
        .live_cls_i (live_cls),
        .lat_cls_i  (lat_q),
        .rdy_i      (mem_rdy_i),
        .irq_i      (irq_i),
        .nxt_o      (nxt)
    );

    icy_strobe_dec #(.NUM_ST(NUM_ST)) u_dec (
        .cur_i         (cur_q),
        .lat_cls_i     (lat_q),
        .rdy_i         (mem_rdy_i),
        .state_oh_o    (state_oh_o),
        .mem_rd_o      (mem_rd_o),
        .mem_wr_o      (mem_wr_o),
        .pc_inc_o      (pc_inc_o),
        .pc_jump_o     (pc_jump_o),
        .pc_vec_o      (pc_vec_o),
        .ctx_save_o    (ctx_save_o),
        .ctx_restore_o (ctx_restore_o)
    );
endmodule

// File: rtl/icy_sequencer_chk.sv
// Protocol checker for icy_sequencer, attached by bind.
// Assumes: state bit order as listed in the package.
module icy_sequencer_chk #(
    parameter int unsigned NUM_ST = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rdy_i,
    input logic              irq_i,
    input logic [NUM_ST-1:0] state_oh_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic              pc_inc_o,
    input logic              pc_jump_o,
    input logic              pc_vec_o,
    input logic              ctx_save_o,
    input logic              ctx_restore_o
);
    a_r1_reset_home: assert property (@(posedge clk)
        !rst_n |=> (state_oh_o == NUM_ST'(1)));

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh_o) == 1);

    a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh_o[1] && !mem_rdy_i) |=> (state_oh_o[1] && mem_rd_o));

    a_r3_inc_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc_o |=> state_oh_o[2]);

    a_r5_opfetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh_o[4] && !mem_rdy_i) |=> (state_oh_o[4] && mem_rd_o));

    a_r6_store_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_rdy_i) |=> state_oh_o[8]);

    a_r7_quiet_check: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh_o[8] && !irq_i) |=> state_oh_o[0]);

    a_r7_save_then_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save_o |=> (pc_vec_o && !ctx_save_o));

    a_r7_vec_then_iac: assert property (@(posedge clk) disable iff (!rst_n)
        pc_vec_o |=> state_oh_o[0]);

    a_r8_jump_in_do: assert property (@(posedge clk) disable iff (!rst_n)
        pc_jump_o |=> (state_oh_o[6] || state_oh_o[8]));

    a_r9_restore_in_do: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_restore_o |=> (state_oh_o[6] || state_oh_o[8]));
endmodule

bind icy_sequencer icy_sequencer_chk #(.NUM_ST(NUM_ST)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_rdy_i     (mem_rdy_i),
    .irq_i         (irq_i),
    .state_oh_o    (state_oh_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .pc_inc_o      (pc_inc_o),
    .pc_jump_o     (pc_jump_o),
    .pc_vec_o      (pc_vec_o),
    .ctx_save_o    (ctx_save_o),
    .ctx_restore_o (ctx_restore_o)
);

// File: tb/tb_icy_sequencer.sv
// Bench for icy_sequencer: directed and seeded random instructions, with the
// expected state and strobes tracked every cycle.
module tb_icy_sequencer;
    localparam int NS = 11;
    localparam int S_IAC = 0, S_IF = 1, S_IOD = 2, S_OACR = 3, S_OF = 4,
                   S_DO = 5, S_OACW = 6, S_OS = 7, S_ICHK = 8, S_ISAV = 9, S_IVEC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cls_rd = 1'b0, cls_wr = 1'b0, cls_jmp = 1'b0, cls_rti = 1'b0;
    logic mem_rdy = 1'b0, irq = 1'b0;
    logic [NS-1:0] state_oh;
    logic mem_rd, mem_wr, pc_inc, pc_jump, pc_vec, ctx_save, ctx_restore;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit [3:0] cur_cls = '0;   // {rd, wr, jmp, rti}

    always #5 clk = ~clk;

    icy_sequencer dut (
        .clk(clk), .rst_n(rst_n),
        .cls_rd_i(cls_rd), .cls_wr_i(cls_wr), .cls_jmp_i(cls_jmp), .cls_rti_i(cls_rti),
        .mem_rdy_i(mem_rdy), .irq_i(irq),
        .state_oh_o(state_oh), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .pc_inc_o(pc_inc), .pc_jump_o(pc_jump), .pc_vec_o(pc_vec),
        .ctx_save_o(ctx_save), .ctx_restore_o(ctx_restore)
    );

    function automatic string req_of(int s);
        case (s)
            S_IAC:  return "R2";
            S_IF:   return "R2 R3";
            S_IOD:  return "R4 R11";
            S_OACR: return "R4 R5";
            S_OF:   return "R5";
            S_DO:   return "R6 R8 R9 R11";
            S_OACW: return "R6";
            S_OS:   return "R6";
            default: return "R7 R12";
        endcase
    endfunction

    // Expected strobes {rd, wr, inc, jump, vec, save, restore} from the requirements.
    function automatic bit [6:0] exp_strobes(int s, bit rdy, bit [3:0] c);
        return {s == S_IF || s == S_OF, s == S_OS, s == S_IF && rdy,
                s == S_DO && c[1], s == S_IVEC, s == S_ISAV, s == S_DO && c[0]};
    endfunction

    // One cycle: drive inputs, compare state and strobes with the expectation.
    task automatic cyc(int es, bit rdy, bit irq_v);
        bit [6:0] got;
        bit [6:0] exp;
        @(negedge clk);
        rst_n = 1'b1;
        mem_rdy = rdy;
        irq = irq_v;
        if (es == S_IOD) {cls_rd, cls_wr, cls_jmp, cls_rti} = cur_cls;
        else             {cls_rd, cls_wr, cls_jmp, cls_rti} = 4'($urandom);
        #1;
        got = {mem_rd, mem_wr, pc_inc, pc_jump, pc_vec, ctx_save, ctx_restore};
        exp = exp_strobes(es, rdy, cur_cls);
        checks++;
        if (state_oh !== NS'(1 << es) || got !== exp) begin
            failures++;
            $display("FAIL %s state=%b exp=%b strobes=%b exp=%b",
                     req_of(es), state_oh, NS'(1 << es), got, exp);
        end
        checks++;
        if ($countones(state_oh) != 1) begin
            failures++;
            $display("FAIL R10 state=%b expected one-hot", state_oh);
        end
    endtask

    // Memory-facing state: wait cycles with ready low, then one ready cycle.
    task automatic mem_state(int es, int waits);
        for (int i = 0; i < waits; i++) cyc(es, 1'b0, 1'($urandom));
        cyc(es, 1'b1, 1'($urandom));
    endtask

    // One instruction of class c = {rd, wr, jmp, rti}, with interrupt choice.
    task automatic do_instr(bit [3:0] c, bit irq_v, int w_if, int w_of, int w_os);
        cyc(S_IAC, 1'($urandom), 1'($urandom));
        mem_state(S_IF, w_if);
        cur_cls = c;
        cyc(S_IOD, 1'($urandom), 1'($urandom));
        if (c[3]) begin
            cyc(S_OACR, 1'($urandom), 1'($urandom));
            mem_state(S_OF, w_of);
        end
        cyc(S_DO, 1'($urandom), 1'($urandom));
        if (c[2]) begin
            cyc(S_OACW, 1'($urandom), 1'($urandom));
            mem_state(S_OS, w_os);
        end
        cyc(S_ICHK, 1'($urandom), irq_v);
        if (irq_v) begin
            cyc(S_ISAV, 1'($urandom), 1'($urandom));
            cyc(S_IVEC, 1'($urandom), 1'($urandom));
        end
    endtask

    // Hold reset through one edge and check the home state (R1).
    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        checks++;
        if (state_oh !== NS'(1) ||
            {mem_rd, mem_wr, pc_inc, pc_jump, pc_vec, ctx_save, ctx_restore} !== 7'b0) begin
            failures++;
            $display("FAIL R1 state=%b exp=%b strobes=%b exp=0000000", state_oh, NS'(1),
                     {mem_rd, mem_wr, pc_inc, pc_jump, pc_vec, ctx_save, ctx_restore});
        end
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        reset_check();
        // Directed: each read/write combination, long waits (R4, R5, R6).
        do_instr(4'b0000, 1'b0, 0, 0, 0);
        do_instr(4'b1000, 1'b0, 3, 5, 0);
        do_instr(4'b0100, 1'b0, 0, 0, 6);
        do_instr(4'b1100, 1'b0, 2, 4, 3);
        // Jump and return classes (R8, R9).
        do_instr(4'b0010, 1'b0, 1, 0, 0);
        do_instr(4'b0001, 1'b0, 0, 0, 0);
        // Interrupts, back to back (R7).
        do_instr(4'b1100, 1'b1, 0, 1, 1);
        do_instr(4'b0000, 1'b1, 0, 0, 0);
        // Reset during an operand fetch wait (R1).
        cur_cls = 4'b1000;
        cyc(S_IAC, 1'b0, 1'b0);
        mem_state(S_IF, 0);
        cyc(S_IOD, 1'b0, 1'b0);
        cyc(S_OACR, 1'b0, 1'b0);
        cyc(S_OF, 1'b0, 1'b0);
        reset_check();
        // Random instructions.
        for (int n = 0; n < 400; n++) begin
            do_instr(4'($urandom), 1'(($urandom % 4) == 0),
                     int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule